// File: doc/BRIEF.md
# Framed Serial Sample Output Port

This block sends complex receiver samples to a signal processor over a three-wire serial link. The link has a serial clock, a frame sync and a data line. Each transfer is a time-slot, and it opens after a frame sync. A slot carries the I and Q words of the current sample, most significant bit first. One trailing word follows them, reserved for read-back. In dual real mode a slot holds two channel pairs, which gives five words. In single complex mode it holds one pair and the trailer, which gives three words. The data line has an enable that is high only inside the slot, so the line can be released between slots and other ports can share it.

As bus master, the port derives the serial clock from the system clock at half its rate. When a sample-ready strobe arrives, the port raises frame sync for one serial clock cycle and then runs the slot. As slave, it takes the serial clock and frame sync from outside and oversamples them with the system clock. Frame sync is sampled on falling serial clock edges. All outputs change on rising edges.

A frame-end flag is high during the last bit cycle of the slot. A second port can use this flag directly as its frame sync, so its slot follows straight after this one. The sample words, the trailer and the mode are captured at slot start. New samples can therefore arrive while a slot is running without disturbing it.

Top module: `slot_serial_tx`

## Requirements
- R1: In master mode the serial clock output toggles on every system clock cycle, giving half the system clock rate.
- R2: In master mode a sample-ready strobe causes frame sync to go high on one serial clock rising edge. Frame sync stays high for exactly one serial clock cycle. The first data bit appears on the next rising edge, and frame sync is low from that edge on.
- R3: Data leaves most significant bit first. The first bit is bit W-1 of channel A I, on the first rising edge after the frame sync was sampled. One further bit follows on each later rising edge.
- R4: In dual real mode (mode input 1) the slot carries A-I, A-Q, B-I, B-Q and then the trailer word, 5*W bits in total.
- R5: In single complex mode (mode input 0) the slot carries A-I, A-Q and then the trailer word, 3*W bits in total.
- R6: The trailer word carries the read-back input when its valid flag was high at slot start; otherwise every trailer bit is 0.
- R7: The data enable is high from the first bit to the last bit of the slot and low at all other times. The data line is 0 whenever the enable is low.
- R8: The frame-end output is high only while the last bit of a slot is on the line. It falls together with the data enable.
- R9: In slave mode, a frame sync sampled high on an external falling edge starts a slot on the next external rising edge. The serial clock and frame sync outputs stay low in this mode.
- R10: In slave mode, frame syncs sampled while a slot is running are ignored. The slot keeps its length, and no new slot follows unless a new sync arrives.
- R11: The sample words, the trailer and the mode are captured at slot start. Changing these inputs during a slot does not alter the bits sent.
- R12: After reset all outputs are low: serial clock, frame sync, data, data enable and frame end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = generate serial clock and sync, 0 = accept them |
| dual_i | input | 1 | 1 = dual real (5 words), 0 = single complex (3 words) |
| sclk_i | input | 1 | External serial clock (slave mode) |
| fsync_i | input | 1 | External frame sync (slave mode) |
| smp_rdy_i | input | 1 | One-cycle strobe: new sample ready (master mode) |
| ai_i | input | W | Channel A in-phase word |
| aq_i | input | W | Channel A quadrature word |
| bi_i | input | W | Channel B in-phase word |
| bq_i | input | W | Channel B quadrature word |
| app_i | input | W | Read-back word for the trailer |
| app_vld_i | input | 1 | Read-back word is pending |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| fsync_o | output | 1 | Generated frame sync (master mode) |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Data line enable (low = released) |
| fe_o | output | 1 | Frame-end flag, high during the last bit |

## Verification
A wrong bit counter or a wrong latched mode would show as an enable that stays high too long or drops too early. The frame-end flag would then land on the wrong bit within the same slot, seen at the first slot after the fault. A wrong shift or load path shows as a corrupted word at the bit position where it breaks, as early as the first rising edge of the slot. A fault in the frame-sync handling would show as a second slot with no sync, a missing slot, or a sync pulse wider than one serial cycle. Each of these is visible within a frame or two of serial clock periods.

// File: rtl/slot_serial_pkg.sv
package slot_serial_pkg;

    typedef enum logic {
        CH_SINGLE = 1'b0,
        CH_DUAL   = 1'b1
    } ch_mode_e;

    localparam int unsigned WORDS_DUAL   = 5;
    localparam int unsigned WORDS_SINGLE = 3;

endpackage

// File: rtl/slot_serial_edge.sv
module slot_serial_edge (
    input  logic clk,
    input  logic rst,
    input  logic master_i,
    input  logic sclk_i,
    input  logic fsync_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o,
    output logic ext_fs_o
);

    typedef struct packed {
        logic sclk;
        logic s1;
        logic s2;
        logic fs1;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (master_i) begin
            st_d.sclk = ~st_q.sclk;
            st_d.s1   = 1'b0;
            st_d.s2   = 1'b0;
            st_d.fs1  = 1'b0;
        end else begin
            st_d.sclk = 1'b0;
            st_d.s1   = sclk_i;
            st_d.s2   = st_q.s1;
            st_d.fs1  = fsync_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // An event asserted in this cycle takes effect on the next system edge,
    // together with the generated serial clock transition in master mode.
    assign sclk_o   = st_q.sclk;
    assign rise_o   = master_i ? ~st_q.sclk : (st_q.s1 & ~st_q.s2);
    assign fall_o   = master_i ?  st_q.sclk : (~st_q.s1 & st_q.s2);
    assign ext_fs_o = st_q.fs1;

endmodule

// File: rtl/slot_serial_ctl.sv
module slot_serial_ctl
    import slot_serial_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     master_i,
    input  ch_mode_e mode_i,
    input  logic     smp_rdy_i,
    input  logic     rise_i,
    input  logic     fall_i,
    input  logic     ext_fs_i,
    output logic     fsync_o,
    output logic     load_o,
    output logic     shift_o,
    output logic     active_o,
    output logic     fe_o
);

    localparam int unsigned NB_MAX = WORDS_DUAL * W;
    localparam int unsigned CW     = $clog2(NB_MAX);
    localparam logic [CW-1:0] LAST_DUAL   = CW'(WORDS_DUAL * W - 1);
    localparam logic [CW-1:0] LAST_SINGLE = CW'(WORDS_SINGLE * W - 1);

    typedef struct packed {
        logic          req;
        logic          fs;
        logic          start;
        logic          active;
        ch_mode_e      mode;
        logic [CW-1:0] cnt;
        logic          fe;
    } ctl_st_t;

    ctl_st_t       st_d, st_q;
    logic          samp_fs;
    logic [CW-1:0] last_bit;

    always_comb begin
        st_d     = st_q;
        load_o   = 1'b0;
        shift_o  = 1'b0;
        samp_fs  = master_i ? st_q.fs : ext_fs_i;
        last_bit = (st_q.mode == CH_DUAL) ? LAST_DUAL : LAST_SINGLE;

        if (!master_i) begin
            st_d.req = 1'b0;
            st_d.fs  = 1'b0;
        end

        // Frame sync is honoured only when idle; syncs inside a slot drop.
        if (fall_i && samp_fs && !st_q.active && !st_q.start)
            st_d.start = 1'b1;

        if (rise_i) begin
            if (master_i) begin
                if (st_q.fs) begin
                    st_d.fs = 1'b0;
                end else if (st_q.req && !st_q.active && !st_q.start) begin
                    st_d.fs  = 1'b1;
                    st_d.req = 1'b0;
                end
            end

            if (st_q.start) begin
                st_d.start  = 1'b0;
                st_d.active = 1'b1;
                st_d.mode   = mode_i;
                st_d.cnt    = '0;
                st_d.fe     = 1'b0;
                load_o      = 1'b1;
            end else if (st_q.active) begin
                if (st_q.cnt == last_bit) begin
                    st_d.active = 1'b0;
                    st_d.fe     = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                    st_d.fe  = ((st_q.cnt + 1'b1) == last_bit);
                    shift_o  = 1'b1;
                end
            end
        end

        if (master_i && smp_rdy_i)
            st_d.req = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fsync_o  = st_q.fs;
    assign active_o = st_q.active;
    assign fe_o     = st_q.fe;

endmodule

// File: rtl/slot_serial_shift.sv
module slot_serial_shift
    import slot_serial_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         shift_i,
    input  ch_mode_e     mode_i,
    input  logic [W-1:0] ai_i,
    input  logic [W-1:0] aq_i,
    input  logic [W-1:0] bi_i,
    input  logic [W-1:0] bq_i,
    input  logic [W-1:0] app_i,
    input  logic         app_vld_i,
    output logic         bit_o
);

    localparam int unsigned FW  = WORDS_DUAL * W;
    localparam int unsigned PAD = (WORDS_DUAL - WORDS_SINGLE) * W;

    typedef struct packed {
        logic [FW-1:0] sr;
    } sh_st_t;

    sh_st_t       st_d, st_q;
    logic [W-1:0] trailer;

    always_comb begin
        st_d    = st_q;
        trailer = app_vld_i ? app_i : '0;
        if (load_i) begin
            if (mode_i == CH_DUAL)
                st_d.sr = {ai_i, aq_i, bi_i, bq_i, trailer};
            else
                st_d.sr = {ai_i, aq_i, trailer, {PAD{1'b0}}};
        end else if (shift_i) begin
            st_d.sr = {st_q.sr[FW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bit_o = st_q.sr[FW-1];

endmodule

// File: rtl/slot_serial_tx.sv
module slot_serial_tx
    import slot_serial_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         master_i,
    input  logic         dual_i,
    input  logic         sclk_i,
    input  logic         fsync_i,
    input  logic         smp_rdy_i,
    input  logic [W-1:0] ai_i,
    input  logic [W-1:0] aq_i,
    input  logic [W-1:0] bi_i,
    input  logic [W-1:0] bq_i,
    input  logic [W-1:0] app_i,
    input  logic         app_vld_i,
    output logic         sclk_o,
    output logic         fsync_o,
    output logic         sdo_o,
    output logic         sdo_oe_o,
    output logic         fe_o
);

    logic     rise_ev, fall_ev, ext_fs;
    logic     load_s, shift_s, active_s, bit_s;
    ch_mode_e mode_s;

    assign mode_s = dual_i ? CH_DUAL : CH_SINGLE;

    slot_serial_edge edge_i (
        .clk      (clk),
        .rst      (rst),
        .master_i (master_i),
        .sclk_i   (sclk_i),
        .fsync_i  (fsync_i),
        .sclk_o   (sclk_o),
        .rise_o   (rise_ev),
        .fall_o   (fall_ev),
        .ext_fs_o (ext_fs)
    );

    slot_serial_ctl #(.W(W)) ctl_i (
        .clk       (clk),
        .rst       (rst),
        .master_i  (master_i),
        .mode_i    (mode_s),
        .smp_rdy_i (smp_rdy_i),
        .rise_i    (rise_ev),
        .fall_i    (fall_ev),
        .ext_fs_i  (ext_fs),
        .fsync_o   (fsync_o),
        .load_o    (load_s),
        .shift_o   (shift_s),
        .active_o  (active_s),
        .fe_o      (fe_o)
    );

    slot_serial_shift #(.W(W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_s),
        .shift_i   (shift_s),
        .mode_i    (mode_s),
        .ai_i      (ai_i),
        .aq_i      (aq_i),
        .bi_i      (bi_i),
        .bq_i      (bq_i),
        .app_i     (app_i),
        .app_vld_i (app_vld_i),
        .bit_o     (bit_s)
    );

    assign sdo_oe_o = active_s;
    assign sdo_o    = active_s & bit_s;

endmodule

// File: rtl/slot_serial_tx_chk.sv
module slot_serial_tx_chk (
    input logic clk,
    input logic rst,
    input logic master_i,
    input logic sclk_o,
    input logic fsync_o,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic fe_o
);

    // R1
    sclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        master_i |=> (sclk_o != $past(sclk_o)));

    // R2
    fs_outside_slot_chk: assert property (@(posedge clk) disable iff (rst)
        fsync_o |-> !sdo_oe_o);

    // R3
    data_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (master_i && !sclk_o) |-> ($stable(sdo_o) && $stable(sdo_oe_o) && $stable(fe_o)));

    // R7
    released_low_chk: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe_o |-> !sdo_o);

    // R8
    fe_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        fe_o |-> sdo_oe_o);

    // R8
    fe_before_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sdo_oe_o) |-> $past(fe_o));

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master_i |-> (!sclk_o && !fsync_o));

endmodule

bind slot_serial_tx slot_serial_tx_chk chk_i (.*);

// File: tb/slot_serial_tx_tb.sv
module slot_serial_tx_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst, master, dual, sclk_in, fs_in, smp_rdy, app_vld;
    logic [W-1:0] ai, aq, bi, bq, app;
    logic         sclk_out, fs_out, sdo, oe, fe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    slot_serial_tx #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .master_i(master), .dual_i(dual),
        .sclk_i(sclk_in), .fsync_i(fs_in), .smp_rdy_i(smp_rdy),
        .ai_i(ai), .aq_i(aq), .bi_i(bi), .bq_i(bq),
        .app_i(app), .app_vld_i(app_vld),
        .sclk_o(sclk_out), .fsync_o(fs_out), .sdo_o(sdo),
        .sdo_oe_o(oe), .fe_o(fe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [79:0] frame_vec(input bit d, input logic [W-1:0] a0,
            input logic [W-1:0] a1, input logic [W-1:0] b0, input logic [W-1:0] b1,
            input logic [W-1:0] t, input bit tv);
        logic [W-1:0] tw = tv ? t : '0;
        return d ? {a0, a1, b0, b1, tw} : {a0, a1, tw, 32'h0};
    endfunction

    task automatic do_reset(input bit m);
        @(negedge clk);
        rst = 1'b1; master = m; sclk_in = 1'b0; fs_in = 1'b0; smp_rdy = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Master clock toggles every cycle: return at the next sample showing sclk high.
    task automatic next_rise();
        do @(negedge clk); while (sclk_out !== 1'b1);
    endtask

    task automatic test_reset();
        do_reset(1'b0);
        @(negedge clk);
        chk({sclk_out, fs_out, sdo, oe, fe} == 5'b0, "R12", "outputs after reset",
            {sclk_out, fs_out, sdo, oe, fe}, 0);
    endtask

    task automatic test_clock_rate();
        bit ok = 1'b1;
        logic prev;
        do_reset(1'b1);
        @(negedge clk);
        prev = sclk_out;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (sclk_out == prev) ok = 1'b0;
            prev = sclk_out;
        end
        chk(ok, "R1", "serial clock toggles every system cycle", ok, 1);
    endtask

    task automatic run_master(input bit d, input logic [W-1:0] a0, input logic [W-1:0] a1,
            input logic [W-1:0] b0, input logic [W-1:0] b1, input logic [W-1:0] t,
            input bit tv, input bit mutate, input string req);
        int n = d ? 80 : 48;
        logic [79:0] exp = frame_vec(d, a0, a1, b0, b1, t, tv);
        logic [79:0] got = '0;
        bit found = 1'b0, oe_ok = 1'b1, fe_ok = 1'b1;
        @(negedge clk);
        dual = d; ai = a0; aq = a1; bi = b0; bq = b1; app = t; app_vld = tv;
        smp_rdy = 1'b1;
        @(negedge clk);
        smp_rdy = 1'b0;
        for (int i = 0; i < 20 && !found; i++) begin
            next_rise();
            if (fs_out) found = 1'b1;
        end
        chk(found && !oe, "R2", "frame sync seen with line released", {found, oe}, 2'b10);
        for (int k = 0; k < n; k++) begin
            next_rise();
            if (k == 0) chk(!fs_out, "R2", "frame sync low at first bit", fs_out, 0);
            if (mutate && k == 6) begin
                dual = ~d; ai = ~a0; aq = ~a1; bi = ~b0; bq = ~b1; app = ~t; app_vld = ~tv;
            end
            got[79-k] = sdo;
            if (!oe) oe_ok = 1'b0;
            if (fe != (k == n - 1)) fe_ok = 1'b0;
        end
        chk(got == exp, req, "frame bits", got, exp);
        chk(oe_ok, "R7", "enable high across slot", oe_ok, 1);
        chk(fe_ok, "R8", "frame end only on last bit", fe_ok, 1);
        next_rise();
        chk(!oe && !fe, "R7", "line released after slot", {oe, fe}, 0);
    endtask

    task automatic slave_tick(input logic fsv, output logic s_sdo, output logic s_oe,
                              output logic s_fe);
        @(negedge clk);
        sclk_in = 1'b1; fs_in = fsv;
        repeat (4) @(negedge clk);
        s_sdo = sdo; s_oe = oe; s_fe = fe;
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_slave(input bit d, input logic [W-1:0] a0, input logic [W-1:0] a1,
            input logic [W-1:0] b0, input logic [W-1:0] b1, input logic [W-1:0] t,
            input int extra_at);
        int n = d ? 80 : 48;
        logic [79:0] exp = frame_vec(d, a0, a1, b0, b1, t, 1'b1);
        logic [79:0] got = '0;
        logic s_sdo, s_oe, s_fe;
        bit oe_ok = 1'b1, fe_ok = 1'b1, idle_ok = 1'b1;
        dual = d; ai = a0; aq = a1; bi = b0; bq = b1; app = t; app_vld = 1'b1;
        slave_tick(1'b1, s_sdo, s_oe, s_fe);
        chk(!s_oe, "R9", "no data during sync cycle", s_oe, 0);
        for (int k = 0; k < n; k++) begin
            slave_tick(k == extra_at, s_sdo, s_oe, s_fe);
            got[79-k] = s_sdo;
            if (!s_oe) oe_ok = 1'b0;
            if (s_fe != (k == n - 1)) fe_ok = 1'b0;
        end
        chk(got == exp, d ? "R9" : "R5", "slave frame bits", got, exp);
        chk(oe_ok && fe_ok, "R10", "slot length kept despite extra sync",
            {oe_ok, fe_ok}, 2'b11);
        for (int k = 0; k < 4; k++) begin
            slave_tick(1'b0, s_sdo, s_oe, s_fe);
            if (s_oe || s_fe) idle_ok = 1'b0;
        end
        chk(idle_ok, "R10", "no slot without a fresh sync", idle_ok, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; master = 1'b0; dual = 1'b1; sclk_in = 1'b0; fs_in = 1'b0;
        smp_rdy = 1'b0; app_vld = 1'b0;
        ai = '0; aq = '0; bi = '0; bq = '0; app = '0;
        test_reset();
        test_clock_rate();
        // R4: dual order with pending trailer
        run_master(1'b1, 16'hA1C3, 16'h5E07, 16'h8001, 16'h3FFE, 16'h0A5A, 1'b1, 1'b0, "R4");
        // R6: trailer zero when nothing pending, single mode R5
        run_master(1'b0, 16'hFFFF, 16'h1234, 16'hDEAD, 16'hBEEF, 16'hFFFF, 1'b0, 1'b0, "R6");
        // R11: inputs and mode flipped mid-slot
        run_master(1'b1, 16'h0F0F, 16'hC0DE, 16'h7777, 16'h8888, 16'h4242, 1'b1, 1'b1, "R11");
        // R3: MSB-first on a walking pattern
        run_master(1'b0, 16'h8000, 16'h0001, 16'h0000, 16'h0000, 16'h4000, 1'b1, 1'b0, "R3");
        do_reset(1'b0);
        run_slave(1'b1, 16'h9ABC, 16'h1357, 16'h2468, 16'hFACE, 16'h600D, 10);
        run_slave(1'b0, 16'h0123, 16'hCAFE, 16'h0000, 16'h0000, 16'h8421, 47);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

endmodule